// File: doc/BRIEF.md
# Flag-Producing Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a datapath word of `W` bits (8 by default). Two operands, a one-bit carry input (normally the stored carry flag from an earlier operation) and a 5-bit operation code go in. A result word and five status bits come out. The enclosing pipeline registers the result and the flags on its own clock. The block holds no state.

The operations are grouped into three units. The add/subtract unit covers sums and differences with and without carry or borrow, negation, increment and decrement. The bitwise unit covers pass-through, AND, OR, XOR and one's complement. The single-position shifter covers logical and arithmetic shifts, plain rotates and rotates through carry.

One carry output serves three purposes. It carries out of additions, it reports a borrow from subtractions, and it holds the bit pushed out of a shift. A shared flag stage derives zero, negative and parity from the selected result.

Top module: `flag_alu`

## Requirements
- R1: ADD (code 0) gives Y = (A+B) mod 2^W with carry = 1 when the unsigned sum exceeds 2^W-1. ADC (code 1) does the same with the carry input added.
- R2: SUB (code 2) gives Y = (A-B) mod 2^W. SBB (code 3) gives (A-B-carry_in) mod 2^W. In both, carry = 1 exactly when the unsigned difference is negative (borrow).
- R3: NEG (code 4) gives 0-A with carry = 1 when A is not zero. INC (code 5) gives A+1 with carry = 1 when A is all ones. DEC (code 6) gives A-1 with carry = 1 when A is zero.
- R4: For codes 0 to 6, overflow = 1 exactly when the true signed (two's complement) result lies outside [-2^(W-1), 2^(W-1)-1].
- R5: PASS (code 7) gives Y = A. AND (8), OR (9) and XOR (10) combine A and B bit by bit. NOT (11) inverts A. All five clear carry and overflow.
- R6: SHL (code 12) shifts A left one place and SHR (code 13) shifts it right one place, each bringing in a 0. Carry receives the bit shifted out. Overflow is 0.
- R7: SAL (code 14) shifts left as SHL does, with overflow = 1 when A's two top bits differ. SAR (code 15) shifts right while keeping the sign bit, with carry = A[0] and overflow = 0.
- R8: ROL (code 16) and ROR (code 17) rotate A one place left or right. The bit that wraps around is also copied to carry. Overflow is 0.
- R9: RCL (code 18) and RCR (code 19) rotate the W+1-bit ring formed by carry_in and A. Carry_in enters the vacated end, and the bit leaving A appears on carry. Overflow is 0.
- R10: zero = 1 exactly when every bit of Y is 0. negative = Y's most significant bit.
- R11: parity = 1 when Y holds an even number of ones, and 0 when it holds an odd number.
- R12: Codes 20 to 31 give Y = 0 with carry and overflow cleared, so zero = 1, negative = 0 and parity = 1.
- R13: Carry_in affects the outputs only for codes 1, 3, 18 and 19. For every other code, all six outputs are identical for carry_in 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | W | First operand; the one shifted, rotated, negated, incremented or decremented |
| b_i | input | W | Second operand |
| carry_i | input | 1 | Carry or borrow input from the stored carry flag |
| y_o | output | W | Result word |
| carry_o | output | 1 | Carry out, borrow, or shifted-out bit |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Most significant bit of the result |
| ovf_o | output | 1 | Signed overflow |
| parity_o | output | 1 | Even number of ones in the result |

## Verification
The embedded checks assume that the operation code, operands and carry input are settled two-state values whenever combinational logic is evaluated. They also assume that codes above 19 are legal and must produce the quiet all-zero result. The stimulus changes all inputs together in one step and samples outputs one picosecond later. It sweeps all 32 codes over every operand pair and both carry values. It then applies seeded random vectors and named corner cases. As a result, each code, including the unused ones, reaches the checks with fully defined inputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 5;
  localparam int OP_USED = 20;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_NEG = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_PASS = 5'd7,
    OP_AND = 5'd8,  OP_OR  = 5'd9,  OP_XOR = 5'd10, OP_NOT = 5'd11,
    OP_SHL = 5'd12, OP_SHR = 5'd13, OP_SAL = 5'd14, OP_SAR = 5'd15,
    OP_ROL = 5'd16, OP_ROR = 5'd17, OP_RCL = 5'd18, OP_RCR = 5'd19
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub import alu_pkg::*; #(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         carry,
  output logic         ovf
);
  localparam int M = W - 1;

  logic [W-1:0] lhs, rhs;
  logic         cadd, borrow_mode;
  logic [W:0]   sum;

  always_comb begin
    lhs = a;
    rhs = b;
    cadd = 1'b0;
    borrow_mode = 1'b0;
    case (op)
      OP_ADC: cadd = cin;
      OP_SUB: begin rhs = ~b; cadd = 1'b1; borrow_mode = 1'b1; end
      OP_SBB: begin rhs = ~b; cadd = ~cin; borrow_mode = 1'b1; end
      OP_NEG: begin lhs = '0; rhs = ~a; cadd = 1'b1; borrow_mode = 1'b1; end
      OP_INC: begin rhs = '0; cadd = 1'b1; end
      OP_DEC: begin rhs = ~(W'(1)); cadd = 1'b1; borrow_mode = 1'b1; end
      default: ;
    endcase
  end

  assign sum   = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cadd};
  assign y     = sum[M:0];
  assign carry = sum[W] ^ borrow_mode;
  assign ovf   = (lhs[M] == rhs[M]) && (sum[M] != lhs[M]);

  always_comb begin
    if (op == OP_INC)
      a_r3_inc_wraps: assert (carry == (y == '0))
        else $error("INC carry disagrees with wrap to zero");
    if (op == OP_NEG)
      a_r3_neg_borrow: assert (carry == (a != '0))
        else $error("NEG borrow disagrees with nonzero operand");
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise import alu_pkg::*; #(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter import alu_pkg::*; #(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         carry,
  output logic         ovf
);
  localparam int M = W - 1;

  always_comb begin
    y = '0;
    carry = 1'b0;
    ovf = 1'b0;
    case (op)
      OP_SHL: begin y = {a[M-1:0], 1'b0}; carry = a[M]; end
      OP_SAL: begin y = {a[M-1:0], 1'b0}; carry = a[M]; ovf = a[M] ^ a[M-1]; end
      OP_SHR: begin y = {1'b0, a[M:1]};   carry = a[0]; end
      OP_SAR: begin y = {a[M], a[M:1]};   carry = a[0]; end
      OP_ROL: begin y = {a[M-1:0], a[M]}; carry = a[M]; end
      OP_ROR: begin y = {a[0], a[M:1]};   carry = a[0]; end
      OP_RCL: begin y = {a[M-1:0], cin};  carry = a[M]; end
      OP_RCR: begin y = {cin, a[M:1]};    carry = a[0]; end
      default: ;
    endcase
  end

  always_comb begin
    if (op == OP_ROL || op == OP_ROR)
      a_r8_ring_keeps_ones: assert ($countones(y) == $countones(a))
        else $error("plain rotate changed the number of ones");
    if (op == OP_RCL || op == OP_RCR)
      a_r9_carry_ring_keeps_ones: assert ($countones({y, carry}) == $countones({a, cin}))
        else $error("carry rotate changed the number of ones in the ring");
    if (op == OP_SAR)
      a_r7_sign_kept: assert (y[M] == a[M])
        else $error("arithmetic right shift lost the sign");
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] y,
  output logic         zero,
  output logic         neg,
  output logic         parity
);
  assign zero   = ~|y;
  assign neg    = y[W-1];
  assign parity = ~^y;

  always_comb begin
    a_r10_zero_not_negative: assert (!(zero && neg))
      else $error("zero and negative both set");
    a_r11_zero_has_even_parity: assert (!zero || parity)
      else $error("all-zero result reported odd parity");
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu import alu_pkg::*; #(
  parameter int W = 8
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            carry_i,
  output logic [W-1:0]    y_o,
  output logic            carry_o,
  output logic            zero_o,
  output logic            neg_o,
  output logic            ovf_o,
  output logic            parity_o
);
  alu_op_e      op;
  logic [W-1:0] as_y, bw_y, sh_y;
  logic         as_c, as_v, sh_c, sh_v;
  logic         sel_as, sel_bw, sel_sh;

  assign op     = alu_op_e'(op_i);
  assign sel_as = op_i <= OP_DEC;
  assign sel_bw = (op_i >= OP_PASS) && (op_i <= OP_NOT);
  assign sel_sh = (op_i >= OP_SHL) && (op_i <= OP_RCR);

  alu_addsub  #(.W(W)) u_addsub  (.op(op), .a(a_i), .b(b_i), .cin(carry_i),
                                  .y(as_y), .carry(as_c), .ovf(as_v));
  alu_bitwise #(.W(W)) u_bitwise (.op(op), .a(a_i), .b(b_i), .y(bw_y));
  alu_shifter #(.W(W)) u_shifter (.op(op), .a(a_i), .cin(carry_i),
                                  .y(sh_y), .carry(sh_c), .ovf(sh_v));

  always_comb begin
    y_o = '0;
    carry_o = 1'b0;
    ovf_o = 1'b0;
    if (sel_as) begin
      y_o = as_y; carry_o = as_c; ovf_o = as_v;
    end else if (sel_bw) begin
      y_o = bw_y;
    end else if (sel_sh) begin
      y_o = sh_y; carry_o = sh_c; ovf_o = sh_v;
    end
  end

  alu_flags #(.W(W)) u_flags (.y(y_o), .zero(zero_o), .neg(neg_o), .parity(parity_o));

  always_comb begin
    if (op_i == OP_ADD)
      a_r1_add_sum: assert ({carry_o, y_o} == {1'b0, a_i} + {1'b0, b_i})
        else $error("ADD result or carry wrong");
    if (op_i == OP_PASS)
      a_r5_pass_copies: assert (y_o == a_i)
        else $error("PASS altered the operand");
    if (sel_bw)
      a_r5_no_carry_ovf: assert (!carry_o && !ovf_o)
        else $error("bitwise op raised carry or overflow");
    if (op_i >= OP_USED)
      a_r12_unused_quiet: assert (y_o == '0 && !carry_o && !ovf_o && zero_o)
        else $error("unused code produced activity");
    a_r11_parity_count: assert (parity_o == ($countones(y_o) % 2 == 0))
      else $error("parity flag disagrees with ones count");
  end
endmodule

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb_top;
  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0] y;
    logic c, z, n, v, p;
  } res_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [4:0]   op_i;
  logic [W-1:0] a_i, b_i;
  logic         carry_i;
  logic [W-1:0] y_o;
  logic         carry_o, zero_o, neg_o, ovf_o, parity_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  flag_alu #(.W(W)) dut_i (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .y_o(y_o), .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o),
    .ovf_o(ovf_o), .parity_o(parity_o)
  );

  function automatic bit out8(int v);
    return (v > 127) || (v < -128);
  endfunction

  function automatic string req_of(int op);
    if (op <= 1) return "R1";
    if (op <= 3) return "R2";
    if (op <= 6) return "R3";
    if (op <= 11) return "R5";
    if (op <= 13) return "R6";
    if (op <= 15) return "R7";
    if (op <= 17) return "R8";
    if (op <= 19) return "R9";
    return "R12";
  endfunction

  function automatic res_t model(int op, logic [7:0] a, logic [7:0] b, logic ci);
    res_t r;
    int ua = int'(a), ub = int'(b), uc = int'(ci);
    int sa = int'($signed(a)), sb = int'($signed(b));
    int t;
    r = '0;
    case (op)
      0:  begin t = ua + ub;      r.y = 8'(t); r.c = t > 255; r.v = out8(sa + sb); end
      1:  begin t = ua + ub + uc; r.y = 8'(t); r.c = t > 255; r.v = out8(sa + sb + uc); end
      2:  begin t = ua - ub;      r.y = 8'(t); r.c = t < 0;   r.v = out8(sa - sb); end
      3:  begin t = ua - ub - uc; r.y = 8'(t); r.c = t < 0;   r.v = out8(sa - sb - uc); end
      4:  begin t = -ua;          r.y = 8'(t); r.c = ua != 0; r.v = out8(-sa); end
      5:  begin t = ua + 1;       r.y = 8'(t); r.c = t > 255; r.v = out8(sa + 1); end
      6:  begin t = ua - 1;       r.y = 8'(t); r.c = t < 0;   r.v = out8(sa - 1); end
      7:  r.y = a;
      8:  r.y = a & b;
      9:  r.y = a | b;
      10: r.y = a ^ b;
      11: r.y = ~a;
      12: begin r.y = a << 1; r.c = a[7]; end
      13: begin r.y = a >> 1; r.c = a[0]; end
      14: begin r.y = a << 1; r.c = a[7]; r.v = a[7] != a[6]; end
      15: begin r.y = {a[7], a[7:1]}; r.c = a[0]; end
      16: begin r.y = {a[6:0], a[7]}; r.c = a[7]; end
      17: begin r.y = {a[0], a[7:1]}; r.c = a[0]; end
      18: begin r.y = {a[6:0], ci};   r.c = a[7]; end
      19: begin r.y = {ci, a[7:1]};   r.c = a[0]; end
      default: ;
    endcase
    r.z = (r.y == 8'h00);
    r.n = r.y[7];
    r.p = ($countones(r.y) % 2) == 0;
    return r;
  endfunction

  function automatic res_t got();
    res_t r;
    r.y = y_o; r.c = carry_o; r.z = zero_o; r.n = neg_o; r.v = ovf_o; r.p = parity_o;
    return r;
  endfunction

  task automatic apply(int op, logic [7:0] a, logic [7:0] b, logic ci);
    op_i = 5'(op); a_i = a; b_i = b; carry_i = ci;
    #0.001;
  endtask

  task automatic compare(int op, res_t g, res_t e);
    total++;
    if ({g.y, g.c, g.v} != {e.y, e.c, e.v}) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%0b got y=%h c=%0b v=%0b exp y=%h c=%0b v=%0b",
               req_of(op), op, a_i, b_i, carry_i, g.y, g.c, g.v, e.y, e.c, e.v);
    end
    total++;
    if ({g.z, g.n} != {e.z, e.n}) begin
      bad++;
      $display("FAIL R10 op=%0d y=%h got z=%0b n=%0b exp z=%0b n=%0b", op, g.y, g.z, g.n, e.z, e.n);
    end
    total++;
    if (g.p != e.p) begin
      bad++;
      $display("FAIL R11 op=%0d y=%h got p=%0b exp p=%0b", op, g.y, g.p, e.p);
    end
  endtask

  task automatic directed(string tag, int op, logic [7:0] a, logic [7:0] b, logic ci,
                          logic [7:0] ey, logic ec, logic ev);
    apply(op, a, b, ci);
    total++;
    if (y_o !== ey || carry_o !== ec || ovf_o !== ev) begin
      bad++;
      $display("FAIL %s op=%0d got y=%h c=%0b v=%0b exp y=%h c=%0b v=%0b",
               tag, op, y_o, carry_o, ovf_o, ey, ec, ev);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    op_i = 5'd0; a_i = '0; b_i = '0; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // idle inputs: ADD of zeros, all flags at their quiet values (R10, R11)
    total++;
    if (y_o !== 8'h00 || carry_o || ovf_o || !zero_o || neg_o || !parity_o) begin
      bad++;
      $display("FAIL R10 idle state y=%h z=%0b p=%0b exp y=00 z=1 p=1", y_o, zero_o, parity_o);
    end

    // directed corners
    directed("R1",  0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0);
    directed("R1",  1, 8'hFE, 8'h01, 1'b1, 8'h00, 1'b1, 1'b0);
    directed("R2",  2, 8'h00, 8'h01, 1'b0, 8'hFF, 1'b1, 1'b0);
    directed("R2",  3, 8'h05, 8'h05, 1'b1, 8'hFF, 1'b1, 1'b0);
    directed("R3",  4, 8'h80, 8'h00, 1'b0, 8'h80, 1'b1, 1'b1);
    directed("R3",  6, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0);
    directed("R4",  0, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1);
    directed("R4",  5, 8'h7F, 8'h00, 1'b0, 8'h80, 1'b0, 1'b1);
    directed("R7", 15, 8'h81, 8'h00, 1'b0, 8'hC0, 1'b1, 1'b0);
    directed("R7", 14, 8'h40, 8'h00, 1'b0, 8'h80, 1'b0, 1'b1);
    directed("R9", 19, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 1'b0);
    directed("R9", 18, 8'h80, 8'h00, 1'b1, 8'h01, 1'b1, 1'b0);
    directed("R12", 25, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b0);

    // exhaustive sweep, plus carry-in independence (R13)
    for (int op = 0; op < 32; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          res_t r0;
          apply(op, 8'(a), 8'(b), 1'b0);
          r0 = got();
          compare(op, r0, model(op, 8'(a), 8'(b), 1'b0));
          apply(op, 8'(a), 8'(b), 1'b1);
          compare(op, got(), model(op, 8'(a), 8'(b), 1'b1));
          if (!(op == 1 || op == 3 || op == 18 || op == 19)) begin
            total++;
            if (got() != r0) begin
              bad++;
              $display("FAIL R13 op=%0d a=%h b=%h got %h exp %h", op, a, b, got(), r0);
            end
          end
        end
      end
    end

    // seeded random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 2000; i++) begin
      int op = int'($urandom_range(31, 0));
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = 8'($urandom);
      logic ci = 1'($urandom);
      apply(op, a, b, ci);
      compare(op, got(), model(op, a, b, ci));
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got running exp finished");
      summary();
      $finish;
    end
  end
endmodule